// File: doc/BRIEF.md
# Overlapped Windowed Register File

This block is the general-purpose register store of a processor whose procedure calls switch register sets instead of saving them to memory. Software sees 32 logical registers. The lowest ten are shared by every procedure. The upper 22 belong to the active window. A small window pointer selects that window, and a call or a return moves the pointer by one step around a ring of four windows.

Neighbouring windows overlap by six registers. The six registers a caller writes at logical numbers 26 to 31 are, after the call, the callee's logical 10 to 15. Arguments therefore pass with no copying. Each window also owns ten locals at logical 16 to 25 that no other window can reach. The backing store holds 74 physical registers.

There are two combinational read ports and one write port, all addressed by logical number. A write, or a read, in the same cycle as a call or return uses the window that was active before the pointer moves. Saving windows to memory when the ring is exhausted is left to the surrounding core.

Top module: `reg_window_file`

## Requirements
- R1: Logical registers 0 to 9 reach the same storage from every window: a value written there in one window reads back unchanged in all four.
- R2: With window index k = (4 - cwp) mod 4, logical register L in 10..31 selects physical register 10 + ((16·k + L - 10) mod 64), and physical L is selected for L below 10. After reset (cwp 0) logical L maps to physical L.
- R3: After a call, the callee's logical 10+i (i = 0..5) reads what the caller last wrote at logical 26+i.
- R4: A call alone moves cwp to cwp-1 mod 4 (0 becomes 3). A return alone moves it to cwp+1 mod 4 (3 becomes 0). The pointer is visible on `cwp_o`.
- R5: When call and return are both high, or both low, cwp does not change.
- R6: A read or write in the same cycle as a call or return is translated with the pointer value from before that cycle. The new pointer applies from the next clock edge.
- R7: A synchronous active-low reset sets cwp to 0 and clears every physical register to zero.
- R8: The ring closes: the outgoing registers of the window at cwp 1 (logical 26..31) are the incoming registers of the window at cwp 0 (logical 10..15).
- R9: Reads are combinational. A write with `wr_en_i` high lands on the rising edge and is visible on every logical name of that physical register. With `wr_en_i` low, no register changes.
- R10: The locals (logical 16..25) of one window are untouched by writes to any logical number in another window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| call_i | input | 1 | Procedure call: step the window pointer down |
| ret_i | input | 1 | Procedure return: step the window pointer up |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical register to write |
| wr_data_i | input | 32 | Write data |
| rd_a_addr_i | input | 5 | Logical register for read port A |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 5 | Logical register for read port B |
| rd_b_data_o | output | 32 | Read port B data |
| cwp_o | output | 2 | Current window pointer |

## Verification
The bench builds the block with its default parameters: ten globals, six shared and ten local registers per window, four windows and 32-bit data. With only four windows, a walk of four calls or four returns wraps both the pointer and the 64-entry physical ring within a few cycles. It therefore reaches the closing overlap between the last and the first window, and every alias between incoming and outgoing names. A full write-and-read sweep of all 22 windowed names in every window compares each read against an independent address model. That sweep exposes any wrong offset, step or ring size.

// File: rtl/rwf_pkg.sv
// Shared types for the windowed register file.
// Assumes: none; imported by the pointer and top modules.
package rwf_pkg;

    // Pointer command decoded from the call and return inputs.
    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_CALL = 2'd1,
        PTR_RET  = 2'd2
    } ptr_cmd_e;

endpackage

// File: rtl/rwf_window_ptr.sv
// Current window pointer. A call steps down and a return steps up, both
// modulo N_WIN.
// Assumes: cmd_i is already decoded so call and return never both arrive.
module rwf_window_ptr
    import rwf_pkg::*;
#(
    parameter int unsigned N_WIN = 4,
    parameter int unsigned CWP_W = 2
)(
    input  logic             clk,
    input  logic             rst_n,
    input  ptr_cmd_e         cmd_i,
    output logic [CWP_W-1:0] cwp_o
);
    localparam logic [CWP_W-1:0] LAST = CWP_W'(N_WIN - 1);

    logic [CWP_W-1:0] cwp_q;

    // Pointer register: reset to window 0, then step on call or return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q <= '0;
        end else begin
            case (cmd_i)
                PTR_CALL: cwp_q <= (cwp_q == '0)  ? LAST : cwp_q - 1'b1;
                PTR_RET:  cwp_q <= (cwp_q == LAST) ? '0   : cwp_q + 1'b1;
                default:  cwp_q <= cwp_q;
            endcase
        end
    end

    assign cwp_o = cwp_q;

    // R4: a call from the lowest window wraps to the highest.
    assert_call_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == PTR_CALL && cwp_q == '0) |=> (cwp_q == LAST));

    // R4: a return from the highest window wraps to the lowest.
    assert_ret_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == PTR_RET && cwp_q == LAST) |=> (cwp_q == '0));

    // R5: with no net command the pointer keeps its value.
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == PTR_HOLD) |=> $stable(cwp_q));

endmodule

// File: rtl/rwf_addr_map.sv
// Logical-to-physical register number translation. Globals pass straight
// through. Windowed numbers are offset by the window base on a ring of
// N_WIN * WIN_STEP registers placed just above the globals.
// Assumes: cwp_i < N_WIN.
module rwf_addr_map #(
    parameter int unsigned N_GLOBAL = 10,
    parameter int unsigned WIN_STEP = 16,
    parameter int unsigned N_WIN    = 4,
    parameter int unsigned LA_W     = 5,
    parameter int unsigned PA_W     = 7,
    parameter int unsigned CWP_W    = 2
)(
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [LA_W-1:0]  log_addr_i,
    output logic [PA_W-1:0]  phys_addr_o
);
    localparam int unsigned RING = N_WIN * WIN_STEP;

    // Translate: window index runs opposite to the pointer, so a call
    // (pointer down) advances one window up the ring.
    always_comb begin
        int unsigned win_idx;
        int unsigned ring_pos;
        win_idx  = (N_WIN - 32'(cwp_i)) % N_WIN;
        ring_pos = 0;
        if (32'(log_addr_i) < N_GLOBAL) begin
            phys_addr_o = PA_W'(log_addr_i);
        end else begin
            ring_pos    = (win_idx * WIN_STEP + 32'(log_addr_i) - N_GLOBAL) % RING;
            phys_addr_o = PA_W'(N_GLOBAL + ring_pos);
        end
    end

endmodule

// File: rtl/rwf_storage.sv
// Physical register array with one synchronous write port and N_RD
// combinational read ports.
// Assumes: addresses arrive already translated; out-of-range ones are ignored.
module rwf_storage #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_PHYS = 74,
    parameter int unsigned PA_W   = 7,
    parameter int unsigned N_RD   = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PA_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PA_W-1:0]   rd_addr_i [N_RD],
    output logic [DATA_W-1:0] rd_data_o [N_RD]
);
    logic [DATA_W-1:0] mem_q [N_PHYS];

    // Storage update: clear on reset, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(N_PHYS); i++) mem_q[i] <= '0;
        end else if (wr_en_i && 32'(wr_addr_i) < N_PHYS) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    // Read ports: combinational lookup, one per port.
    for (genvar g = 0; g < int'(N_RD); g++) begin : g_rd
        assign rd_data_o[g] = (32'(rd_addr_i[g]) < N_PHYS) ? mem_q[rd_addr_i[g]] : '0;
    end

    // R9: an enabled write is present in the array after the edge.
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mem_q[$past(wr_addr_i)] == $past(wr_data_i)));

endmodule

// File: rtl/reg_window_file.sv
// Windowed register file top. Decodes call and return into a pointer step,
// translates the three logical addresses with the current pointer, and
// drives the physical array.
// Assumes: a caller that needs a free window has already saved one to memory.
module reg_window_file
    import rwf_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned N_GLOBAL = 10,
    parameter int unsigned N_SHARE  = 6,
    parameter int unsigned N_LOCAL  = 10,
    parameter int unsigned N_WIN    = 4,
    localparam int unsigned N_LOGICAL = N_GLOBAL + 2 * N_SHARE + N_LOCAL,
    localparam int unsigned LA_W      = $clog2(N_LOGICAL),
    localparam int unsigned CWP_W     = (N_WIN > 1) ? $clog2(N_WIN) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              wr_en_i,
    input  logic [LA_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [LA_W-1:0]   rd_a_addr_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [LA_W-1:0]   rd_b_addr_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    output logic [CWP_W-1:0]  cwp_o
);
    localparam int unsigned WIN_STEP = N_SHARE + N_LOCAL;
    localparam int unsigned N_PHYS   = N_GLOBAL + N_WIN * WIN_STEP;
    localparam int unsigned PA_W     = $clog2(N_PHYS);
    localparam int unsigned N_XLAT   = 3;   // 0: read A, 1: read B, 2: write

    ptr_cmd_e          cmd;
    logic [CWP_W-1:0]  cwp;
    logic [LA_W-1:0]   log_addr  [N_XLAT];
    logic [PA_W-1:0]   phys_addr [N_XLAT];
    logic [PA_W-1:0]   rd_phys   [2];
    logic [DATA_W-1:0] rd_data   [2];

    // Command decode: simultaneous call and return cancel out.
    always_comb begin
        if (call_i && !ret_i)      cmd = PTR_CALL;
        else if (ret_i && !call_i) cmd = PTR_RET;
        else                       cmd = PTR_HOLD;
    end

    rwf_window_ptr #(
        .N_WIN (N_WIN),
        .CWP_W (CWP_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_i (cmd),
        .cwp_o (cwp)
    );

    assign log_addr[0] = rd_a_addr_i;
    assign log_addr[1] = rd_b_addr_i;
    assign log_addr[2] = wr_addr_i;

    // One translator per port, all driven by the pre-update pointer.
    for (genvar p = 0; p < int'(N_XLAT); p++) begin : g_xlat
        rwf_addr_map #(
            .N_GLOBAL (N_GLOBAL),
            .WIN_STEP (WIN_STEP),
            .N_WIN    (N_WIN),
            .LA_W     (LA_W),
            .PA_W     (PA_W),
            .CWP_W    (CWP_W)
        ) u_map (
            .cwp_i       (cwp),
            .log_addr_i  (log_addr[p]),
            .phys_addr_o (phys_addr[p])
        );
    end

    assign rd_phys[0] = phys_addr[0];
    assign rd_phys[1] = phys_addr[1];

    rwf_storage #(
        .DATA_W (DATA_W),
        .N_PHYS (N_PHYS),
        .PA_W   (PA_W),
        .N_RD   (2)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (phys_addr[2]),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_phys),
        .rd_data_o (rd_data)
    );

    assign rd_a_data_o = rd_data[0];
    assign rd_b_data_o = rd_data[1];
    assign cwp_o       = cwp;

    // R1: global numbers reach the same physical entry whatever the pointer.
    assert_global_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_a_addr_i) < N_GLOBAL) |-> (phys_addr[0] == PA_W'(rd_a_addr_i)));

    // R2: every translated write address falls inside the physical array.
    assert_in_array_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(phys_addr[2]) < N_PHYS));

    // R9: two names of one physical register read the same value.
    assert_alias_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_addr[0] == phys_addr[1]) |-> (rd_a_data_o == rd_b_data_o));

endmodule

// File: tb/test_reg_window_file.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, a monitor on the
// falling edge pops and compares them against the ports.
module test_reg_window_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0;
    logic        ret_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [4:0]  rd_a_addr_i = '0;
    logic [4:0]  rd_b_addr_i = '0;
    logic [31:0] rd_a_data_o;
    logic [31:0] rd_b_data_o;
    logic [1:0]  cwp_o;

    always #2 clk = ~clk;   // 250 MHz

    reg_window_file i_reg_window_file (
        .clk         (clk),
        .rst_n       (rst_n),
        .call_i      (call_i),
        .ret_i       (ret_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .rd_a_addr_i (rd_a_addr_i),
        .rd_a_data_o (rd_a_data_o),
        .rd_b_addr_i (rd_b_addr_i),
        .rd_b_data_o (rd_b_data_o),
        .cwp_o       (cwp_o)
    );

    int          kind_q [$];
    logic [31:0] exp_q  [$];
    string       tag_q  [$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;
    logic [31:0] mdl [74];
    int          mcwp = 0;

    // Address model written from the mapping requirement.
    function automatic int phys_of(int cw, int la);
        int k;
        if (la < 10) return la;
        k = (4 - cw) % 4;
        return 10 + ((k * 16 + la - 10) % 64);
    endfunction

    // Driver: apply one cycle of stimulus, optionally queue one expectation
    // (kind 0: port A, 1: port B, 2: pointer), then update the model.
    task automatic drive(bit c, bit r, bit we, int wa, logic [31:0] wd,
                         int kind, int la, logic [31:0] exp, string tag);
        call_i = c; ret_i = r; wr_en_i = we;
        wr_addr_i = 5'(wa); wr_data_i = wd;
        if (kind == 0) rd_a_addr_i = 5'(la);
        if (kind == 1) rd_b_addr_i = 5'(la);
        if (kind >= 0) begin
            kind_q.push_back(kind);
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(posedge clk); #1;
        if (we) mdl[phys_of(mcwp, wa)] = wd;
        if (c && !r) mcwp = (mcwp + 3) % 4;
        else if (r && !c) mcwp = (mcwp + 1) % 4;
        call_i = 1'b0; ret_i = 1'b0; wr_en_i = 1'b0;
    endtask

    task automatic wr(int la, logic [31:0] d);
        drive(0, 0, 1, la, d, -1, 0, '0, "");
    endtask
    task automatic rd(int la, logic [31:0] exp, string tag);
        drive(0, 0, 0, 0, '0, 0, la, exp, tag);
    endtask
    task automatic rdb(int la, logic [31:0] exp, string tag);
        drive(0, 0, 0, 0, '0, 1, la, exp, tag);
    endtask
    task automatic rdm(int la, string tag);
        rd(la, mdl[phys_of(mcwp, la)], tag);
    endtask
    task automatic chk_cwp(int exp, string tag);
        drive(0, 0, 0, 0, '0, 2, 0, 32'(exp), tag);
    endtask
    task automatic do_call();
        drive(1, 0, 0, 0, '0, -1, 0, '0, "");
    endtask
    task automatic do_ret();
        drive(0, 1, 0, 0, '0, -1, 0, '0, "");
    endtask

    // Monitor: compare one queued item per cycle, away from the rising edge.
    always @(negedge clk) begin
        if (kind_q.size() > 0) begin
            int          k;
            logic [31:0] e;
            logic [31:0] a;
            string       t;
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = (k == 0) ? rd_a_data_o : (k == 1) ? rd_b_data_o : {30'b0, cwp_o};
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 74; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R7: reset state.
        chk_cwp(0, "R7 pointer after reset");
        for (int l = 0; l < 32; l++) rd(l, 32'h0, "R7 register cleared");
        rdb(31, 32'h0, "R7 port B cleared");

        // R2, R9: window at cwp 0 writes and reads back.
        wr(3, 32'h0000_0033);
        wr(12, 32'h0000_0A12);
        wr(20, 32'h0000_0A20);
        wr(28, 32'h0000_0A28);
        rd(3, 32'h0000_0033, "R9 global write");
        rd(12, 32'h0000_0A12, "R2 incoming write");
        rd(20, 32'h0000_0A20, "R2 local write");
        rdb(28, 32'h0000_0A28, "R9 outgoing read on port B");

        // R9: disabled write changes nothing.
        drive(0, 0, 0, 20, 32'hDEAD_BEEF, -1, 0, '0, "");
        rd(20, 32'h0000_0A20, "R9 write enable low ignored");

        // R6: write and read in the call cycle use the old window.
        drive(1, 0, 1, 27, 32'hC0DE_0027, 0, 28, 32'h0000_0A28, "R6 read during call");
        chk_cwp(3, "R4 call from 0 wraps to 3");
        rd(11, 32'hC0DE_0027, "R6 R3 write in call cycle seen by callee");
        rd(12, 32'h0000_0A28, "R3 parameter passed");
        rd(10, 32'h0000_0000, "R3 unwritten parameter");
        rd(3, 32'h0000_0033, "R1 global after call");
        rd(20, 32'h0000_0000, "R10 callee locals private");

        // R5: call and return together leave the pointer alone.
        wr(20, 32'h0000_0B20);
        wr(28, 32'h0000_0B28);
        drive(1, 1, 0, 0, '0, -1, 0, '0, "");
        chk_cwp(3, "R5 call and return together");
        rd(20, 32'h0000_0B20, "R5 window kept");

        // R3, R8: walk around the ring.
        do_call();
        chk_cwp(2, "R4 call steps down");
        rd(12, 32'h0000_0B28, "R3 second hop");
        wr(30, 32'h0000_0C30);
        do_call();
        rd(14, 32'h0000_0C30, "R3 third hop");
        wr(26, 32'h0000_0D26);
        wr(31, 32'h0000_0D31);
        wr(20, 32'h0000_0D20);
        wr(9, 32'h0000_0009);
        do_call();
        chk_cwp(0, "R4 fourth call returns to 0");
        rd(10, 32'h0000_0D26, "R8 ring closes low");
        rd(15, 32'h0000_0D31, "R8 ring closes high");
        rd(20, 32'h0000_0A20, "R10 locals survive a full ring");
        rd(12, 32'h0000_0A12, "R8 untouched overlap entry");
        rd(9, 32'h0000_0009, "R1 global written in another window");

        // R4: returns, including the wrap from 3 to 0.
        do_ret();
        chk_cwp(1, "R4 return steps up");
        rd(20, 32'h0000_0D20, "R10 locals after return");
        rdb(26, 32'h0000_0D26, "R8 outgoing name after return");
        do_ret();
        do_ret();
        chk_cwp(3, "R4 return count");
        rd(20, 32'h0000_0B20, "R10 locals after unwinding");
        do_ret();
        chk_cwp(0, "R4 return from 3 wraps to 0");
        rd(3, 32'h0000_0033, "R1 global after unwinding");

        // R2: full sweep of every windowed name in every window.
        for (int w = 0; w < 4; w++) begin
            for (int l = 10; l < 32; l++) wr(l, 32'h5A00_0000 | 32'(w * 256 + l));
            do_call();
        end
        for (int w = 0; w < 4; w++) begin
            for (int l = 0; l < 32; l++) rdm(l, "R2 mapping sweep");
            do_call();
        end

        repeat (2) @(posedge clk);
        if (kind_q.size() != 0) begin
            n_bad++;
            $display("FAIL R9: actual %0d pending expected 0", kind_q.size());
        end
        finished = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule